// File: doc/BRIEF.md
# Region-Locked One-Time-Programmable Fuse Controller

This block guards a 1024-byte one-time-programmable fuse array. A requester sends one program request at a time over a valid/ready port. Each request carries a byte address, a data byte and a dry-run flag. The controller checks the request against the address range, the lock of the region that holds the address, the global programming enable and the set-only nature of fuses. It then programs the new 1-bits into a behavioural fuse array, or leaves the array untouched, and returns a two-bit status one cycle later.

The array is split into four regions. Each region carries its own write lock, and that lock is bit 0 of a fuse byte inside the region. Setting that bit therefore closes the region for good. A dry run goes through every check and returns the status a real write would return, but it changes nothing. This lets a requester confirm that a permanent update is feasible before committing it. A separate combinational read port returns the current contents of any byte.

Top module: `otp_prog_ctrl`

## Requirements
- R1: `req_ready` is high from the second rising edge after reset release onward. Every accepted request (`req_valid` and `req_ready` high at a rising edge) makes `rsp_valid` high for exactly the following cycle. `rsp_valid` is low in every other cycle.
- R2: A request with `req_addr` of 1024 or more returns status 2'b11 (out of range) and programs nothing.
- R3: The regions are bytes 0–127, 128–255, 256–767 and 768–1023. They are locked by bit 0 of bytes 127, 255, 766 and 1023 respectively. A request to an address in a locked region, including that region's own lock byte, returns 2'b01 (locked). The lock byte of an open region can itself be programmed. A lock affects only its own region.
- R4: An in-range, non-dry-run request made while `prog_en` is low returns 2'b01 and programs nothing. A dry run ignores `prog_en`.
- R5: A request whose data lacks any bit that is already 1 in the stored byte returns 2'b10 (clear attempt) and programs nothing.
- R6: When several conditions hold, the status follows this priority: out of range first, then locked or disabled, then clear attempt.
- R7: A request that passes every check returns 2'b00. If it is not a dry run, the stored byte becomes the bitwise OR of the old byte and the data.
- R8: `rsp_prog` is high, together with `rsp_valid`, only when a real write changed the stored byte. A request whose data equals the stored byte returns 2'b00 with `rsp_prog` low.
- R9: A dry run returns the same status as the equivalent real write with `prog_en` high. It never changes the array and never raises `rsp_prog`.
- R10: `rd_data` combinationally shows the current byte at `rd_addr`. A fuse bit that has read as 1 never reads as 0 again until reset.
- R11: Reset models a blank part: every byte reads 0x00, all regions are open and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_en | input | 1 | Global programming enable for real writes |
| req_valid | input | 1 | Program request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 11 | Byte address of the request |
| req_data | input | 8 | Bits to be set in the addressed byte |
| req_dry | input | 1 | Dry run: check only, never program |
| rsp_valid | output | 1 | Response status valid |
| rsp_status | output | 2 | 00 ok, 01 locked/disabled, 10 clear attempt, 11 out of range |
| rsp_prog | output | 1 | The request changed fuse contents |
| rd_addr | input | 10 | Read port byte address |
| rd_data | output | 8 | Current byte at `rd_addr` |

## Verification
The hardest states to reach from the ports are the locked regions and the overlaps of several rejection conditions. Bit 0 of a fuse byte only goes up through an accepted write, and once it is set, that region can never be written again before reset. The random phase therefore draws addresses from small windows around every region boundary and lock byte. It favours data that reuses or extends the stored bits, so that repeats, clear attempts and occasional locks all occur. A second reset then starts a directed pass. That pass closes each region in turn and probes that region, its lock byte and its still-open neighbours with dry runs, clear attempts and out-of-range requests.

// File: rtl/otp_pkg.sv
// Package: shared types for the fuse programming controller.
// Assumes: status encoding is fixed and seen by software-visible tooling.
package otp_pkg;

    // Response status codes, in decreasing priority order 11, 01, 10, 00.
    typedef enum logic [1:0] {
        ST_OK     = 2'b00,
        ST_LOCKED = 2'b01,
        ST_CLEAR  = 2'b10,
        ST_RANGE  = 2'b11
    } otp_status_e;

endpackage

// File: rtl/otp_region_decode.sv
// Module: maps a request address to a region index and flags addresses
// beyond the array. Assumes N_BYTES < 2**ADDR_W and ascending bases.
module otp_region_decode #(
    parameter int ADDR_W  = 11,
    parameter int N_BYTES = 1024,
    parameter int R2_BASE = 128,
    parameter int R3_BASE = 256,
    parameter int R4_BASE = 768
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [1:0]        region,
    output logic              out_of_range
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(N_BYTES);
    localparam logic [ADDR_W-1:0] B2    = ADDR_W'(R2_BASE);
    localparam logic [ADDR_W-1:0] B3    = ADDR_W'(R3_BASE);
    localparam logic [ADDR_W-1:0] B4    = ADDR_W'(R4_BASE);

    // Purpose: compare against region bases and the array limit.
    always_comb begin
        out_of_range = (addr >= LIMIT);
        if (addr < B2)      region = 2'd0;
        else if (addr < B3) region = 2'd1;
        else if (addr < B4) region = 2'd2;
        else                region = 2'd3;
    end
endmodule

// File: rtl/otp_fuse_array.sv
// Module: behavioural fuse storage. Writes OR data into a byte (bits only
// rise). Two combinational read ports, plus the four region lock bits
// taken from bit 0 of their lock bytes. Assumes reset represents a blank part.
module otp_fuse_array #(
    parameter int N_BYTES = 1024,
    parameter int IDX_W   = $clog2(N_BYTES),
    parameter int LOCK_R1 = 127,
    parameter int LOCK_R2 = 255,
    parameter int LOCK_R3 = 766,
    parameter int LOCK_R4 = 1023
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] chk_addr,
    output logic [7:0]       chk_data,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [7:0]       rd_data,
    output logic [3:0]       lock_bits
);
    logic [7:0] mem [N_BYTES];

    // Purpose: clear on reset, otherwise OR new bits into the addressed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_BYTES; i++) mem[i] <= 8'h00;
        end else if (we) begin
            mem[waddr] <= mem[waddr] | wdata;
        end
    end

    assign chk_data = mem[chk_addr];
    assign rd_data  = mem[rd_addr];

    // One lock tap per region; the generate index selects the lock byte.
    for (genvar g = 0; g < 4; g++) begin : g_lock
        localparam int LA = (g == 0) ? LOCK_R1 :
                            (g == 1) ? LOCK_R2 :
                            (g == 2) ? LOCK_R3 : LOCK_R4;
        assign lock_bits[g] = mem[LA][0];
    end
endmodule

// File: rtl/otp_prog_check.sv
// Module: decides the status of one request and whether it programs.
// Priority: range, then lock or disabled enable, then clear attempt.
// Assumes inputs describe a single request in the current cycle.
module otp_prog_check
    import otp_pkg::*;
(
    input  logic        out_of_range,
    input  logic [1:0]  region,
    input  logic [3:0]  lock_bits,
    input  logic        prog_en,
    input  logic        dry,
    input  logic [7:0]  old_byte,
    input  logic [7:0]  new_byte,
    output otp_status_e status,
    output logic        do_write
);
    logic clears;
    logic blocked;

    // Purpose: evaluate the checks in priority order and gate the write.
    always_comb begin
        clears  = |(old_byte & ~new_byte);
        blocked = lock_bits[region] | (!dry && !prog_en);
        if (out_of_range)   status = ST_RANGE;
        else if (blocked)   status = ST_LOCKED;
        else if (clears)    status = ST_CLEAR;
        else                status = ST_OK;
        do_write = (status == ST_OK) && !dry && (new_byte != old_byte);
    end
endmodule

// File: rtl/otp_prog_ctrl.sv
// Module: top of the region-locked fuse programming controller. Takes one
// request per cycle once ready, programs in the accepting cycle and
// returns a registered status one cycle later.
// Assumes: synchronous active-low reset; the reset clears the behavioural array.
module otp_prog_ctrl
    import otp_pkg::*;
#(
    parameter int N_BYTES = 1024,
    parameter int ADDR_W  = 11,
    parameter int IDX_W   = $clog2(N_BYTES),
    parameter int R2_BASE = 128,
    parameter int R3_BASE = 256,
    parameter int R4_BASE = 768,
    parameter int LOCK_R1 = 127,
    parameter int LOCK_R2 = 255,
    parameter int LOCK_R3 = 766,
    parameter int LOCK_R4 = 1023
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    input  logic              req_dry,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic              rsp_prog,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [7:0]        rd_data
);
    logic              ready_q;
    logic              accept;
    logic [1:0]        region;
    logic              out_of_range;
    logic [3:0]        lock_bits;
    logic [7:0]        old_byte;
    otp_status_e       status;
    logic              do_write;
    logic [IDX_W-1:0]  idx;

    assign accept    = req_valid && ready_q;
    assign req_ready = ready_q;
    assign idx       = req_addr[IDX_W-1:0];

    otp_region_decode #(
        .ADDR_W (ADDR_W),
        .N_BYTES(N_BYTES),
        .R2_BASE(R2_BASE),
        .R3_BASE(R3_BASE),
        .R4_BASE(R4_BASE)
    ) u_decode (
        .addr        (req_addr),
        .region      (region),
        .out_of_range(out_of_range)
    );

    otp_fuse_array #(
        .N_BYTES(N_BYTES),
        .IDX_W  (IDX_W),
        .LOCK_R1(LOCK_R1),
        .LOCK_R2(LOCK_R2),
        .LOCK_R3(LOCK_R3),
        .LOCK_R4(LOCK_R4)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (accept && do_write),
        .waddr    (idx),
        .wdata    (req_data),
        .chk_addr (idx),
        .chk_data (old_byte),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .lock_bits(lock_bits)
    );

    otp_prog_check u_check (
        .out_of_range(out_of_range),
        .region      (region),
        .lock_bits   (lock_bits),
        .prog_en     (prog_en),
        .dry         (req_dry),
        .old_byte    (old_byte),
        .new_byte    (req_data),
        .status      (status),
        .do_write    (do_write)
    );

    // Purpose: raise ready one cycle after reset and register the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q    <= 1'b0;
            rsp_valid  <= 1'b0;
            rsp_status <= 2'b00;
            rsp_prog   <= 1'b0;
        end else begin
            ready_q    <= 1'b1;
            rsp_valid  <= accept;
            rsp_status <= accept ? status : 2'b00;
            rsp_prog   <= accept && do_write;
        end
    end
endmodule

// File: rtl/otp_prog_ctrl_chk.sv
// Module: port-level checker for otp_prog_ctrl, attached by bind below.
// Assumes the default 1024-byte array and the fixed status encoding.
module otp_prog_ctrl_chk #(
    parameter int N_BYTES = 1024,
    parameter int ADDR_W  = 11,
    parameter int IDX_W   = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prog_en,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_dry,
    input logic              rsp_valid,
    input logic [1:0]        rsp_status,
    input logic              rsp_prog,
    input logic [IDX_W-1:0]  rd_addr,
    input logic [7:0]        rd_data
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(N_BYTES);
    logic acc;
    assign acc = req_valid && req_ready;

    AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid); // R1
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !rsp_valid); // R1
    AST_RANGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_addr >= LIMIT) |=> (rsp_status == 2'b11 && !rsp_prog)); // R2
    AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_addr < LIMIT && !req_dry && !prog_en) |=> (rsp_status == 2'b01)); // R4
    AST_PROG_MEANS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_prog |-> (rsp_valid && rsp_status == 2'b00)); // R8
    AST_DRY_NO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_dry) |=> !rsp_prog); // R9
    AST_BITS_NEVER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(rd_addr) |-> (($past(rd_data) & ~rd_data) == 8'h00)); // R10
endmodule

bind otp_prog_ctrl otp_prog_ctrl_chk #(
    .N_BYTES(N_BYTES),
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_en   (prog_en),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_dry   (req_dry),
    .rsp_valid (rsp_valid),
    .rsp_status(rsp_status),
    .rsp_prog  (rsp_prog),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
);

// File: tb/otp_prog_ctrl_tb.sv
// Bench: directed corner cases plus seeded random requests, checked
// against a bench-side fuse model and status function.
module otp_prog_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [10:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic        req_dry = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic        rsp_prog;
    logic [9:0]  rd_addr = '0;
    logic [7:0]  rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [7:0] m [1024];

    always #4 clk = ~clk;

    otp_prog_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_dry(req_dry),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_prog(rsp_prog),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit lock_of(input int a);
        if (a < 128)      return m[127][0];
        else if (a < 256) return m[255][0];
        else if (a < 768) return m[766][0];
        else              return m[1023][0];
    endfunction

    function automatic logic [1:0] exp_st(input int a, input logic [7:0] d,
                                          input bit dry, input bit en);
        if (a >= 1024)                      return 2'b11;
        if (lock_of(a) || (!dry && !en))    return 2'b01;
        if ((m[a] & ~d) != 8'h00)           return 2'b10;
        return 2'b00;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 1024; i++) m[i] = 8'h00;
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_req(input int a, input logic [7:0] d, input bit dry,
                          input bit en, input string req);
        logic [1:0] es;
        logic [7:0] old;
        bit ep;
        es  = exp_st(a, d, dry, en);
        old = (a < 1024) ? m[a] : 8'h00;
        ep  = (es == 2'b00) && !dry && (d != old);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a[10:0]; req_data = d;
        req_dry = dry; prog_en = en;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, req, "rsp_valid", rsp_valid, 1);
        chk(rsp_status == es, req, "status", rsp_status, es);
        chk(rsp_prog == ep, req, "rsp_prog", rsp_prog, ep);
        if (ep) m[a] = m[a] | d;
        if (a < 1024) begin
            rd_addr = a[9:0];
            #1;
            chk(rd_data == m[a], req, "readback", rd_data, m[a]);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        int lock_at [4];
        int probe [4];
        lock_at = '{127, 255, 766, 1023};
        probe   = '{0, 200, 767, 800};
        void'($urandom(32'd915));
        do_reset();

        // R11, R1: blank state after reset
        chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        chk(rsp_valid == 1'b0, "R11", "rsp_valid idle", rsp_valid, 0);
        rd_addr = 10'd0; #1;
        chk(rd_data == 8'h00, "R11", "byte 0", rd_data, 0);
        rd_addr = 10'd1023; #1;
        chk(rd_data == 8'h00, "R11", "byte 1023", rd_data, 0);

        do_req(5, 8'h0A, 0, 1, "R7");
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid one cycle", rsp_valid, 0);
        do_req(5, 8'h0A, 0, 1, "R8");
        do_req(5, 8'h0E, 0, 1, "R7");
        do_req(5, 8'h01, 0, 1, "R5");
        do_req(300, 8'hFF, 1, 1, "R9");
        do_req(5, 8'h00, 1, 1, "R9");
        do_req(300, 8'h11, 0, 0, "R4");
        do_req(300, 8'h11, 1, 0, "R4");
        do_req(5, 8'h00, 0, 0, "R6");
        do_req(1024, 8'h01, 0, 1, "R2");
        do_req(2047, 8'h00, 0, 0, "R6");

        // Random phase, addresses near region edges and lock bytes.
        for (int n = 0; n < 3000; n++) begin
            int a;
            int k;
            logic [7:0] d;
            int bases [5];
            bases = '{0, 120, 250, 760, 1016};
            k = $urandom % 40;
            if (k == 0)      a = lock_at[$urandom % 4];
            else if (k < 4)  a = 1024 + ($urandom % 1024);
            else             a = bases[$urandom % 5] + ($urandom % 8);
            case ($urandom % 4)
                0: d = 8'h01;
                1: d = ((a < 1024) ? m[a] : 8'h00) | 8'($urandom);
                2: d = (a < 1024) ? m[a] : 8'h00;
                default: d = 8'($urandom);
            endcase
            do_req(a, d, ($urandom % 5) == 0, ($urandom % 10) != 0, "R7");
        end

        // Lock pass on a fresh part: close regions one by one.
        do_reset();
        for (int r = 0; r < 4; r++) begin
            do_req(probe[r], 8'h80, 0, 1, "R7");
            do_req(lock_at[r], 8'h01, 0, 1, "R3");
            do_req(probe[r], 8'hC0, 0, 1, "R3");
            do_req(probe[r], 8'hC0, 1, 1, "R9");
            do_req(lock_at[r], 8'h01, 0, 1, "R3");
            do_req(probe[r], 8'h00, 0, 1, "R6");
            if (r < 3) do_req(probe[r + 1], 8'h04, 1, 1, "R3");
        end
        do_req(1030, 8'h00, 0, 1, "R2");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule